// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a serial peripheral interface master that software drives through a small set of memory-mapped registers. Software queues transmit words into a FIFO while shifting is held off. It then clears a hold bit, and the queued words go out back to back. Every word shifted in during a transfer is placed in a receive FIFO, and software reads it out later. The word width, the FIFO depth, the number of slave-select lines and the fixed serial clock divider are all parameters. Software cannot change the serial clock rate.

The shift engine is a three-state machine. In `ST_IDLE`, the serial clock rests at its idle level. The transition *start* (from `ST_IDLE` to `ST_SHIFT`) is taken when the controller is enabled, in master mode, not held, and the transmit FIFO holds a word. That transition pops the word into the shifter. `ST_SHIFT` toggles the serial clock every `CLK_DIV` system cycles. After 2×`WORD_W` edges, the transition *last edge* leads to `ST_STORE`. `ST_STORE` pushes the received word, and the transition *done* returns to `ST_IDLE`, where the next word may start at once. The hold bit is tested only in `ST_IDLE`, so a word already in flight always completes.

The registers sit at these byte addresses: control at 0x60, status at 0x64, transmit data at 0x68, receive data at 0x6C and slave select at 0x70. Reads are combinational. A read of the receive data address pops one word.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, control reads 0x100 (hold set, all else clear), status reads 0x05 (both FIFOs empty), every slave-select line is high and the serial clock is low.
- R2: While control bit 8 (hold) is set, no word leaves the transmit FIFO and the serial clock does not toggle.
- R3: Clearing the hold bit shifts out every queued word in FIFO order, 2×WORD_W clock edges per word. The word sampled from the serial input is placed in the receive FIFO, and status bit 2 (transmit empty) rises afterwards.
- R4: Control bit 3 sets the serial clock idle level. With control bit 4 clear, data are sampled on the leading edge of each bit. With bit 4 set, data are sampled on the trailing edge. Output data always change on the opposite edge.
- R5: With control bit 9 set, the least significant bit goes first in both directions. Otherwise the most significant bit goes first.
- R6: With control bit 0 set, the serial output is routed internally to the receive path, the external serial input is ignored, and bit 0 reads back as 1.
- R7: The transmit FIFO accepts one word per write to 0x68 until status bit 3 (transmit full) rises after FIFO_DEPTH writes. A write while it is full is dropped.
- R8: When the receive FIFO is full (status bit 1), further received words are dropped and the stored words stay unchanged.
- R9: Writing 1 to control bit 5 empties the transmit FIFO, and writing 1 to bit 6 empties the receive FIFO. Both bits read back as 0.
- R10: With control bit 7 (manual select) set, the slave-select pins equal the slave-select register at all times, including between words.
- R11: With control bit 7 clear, the slave-select pins are all high while idle and equal the slave-select register while a word is in progress.
- R12: No shifting starts unless both control bit 1 (enable) and bit 2 (master) are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive FIFO at 0x6C) |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational on addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The hardest case to reach is receive-FIFO overflow with the stored words intact. The bench first fills the transmit FIFO until the full flag rises, which also measures the depth, and it adds one write that must be dropped. It then drains that burst without reading any received words. A second burst arrives on a full receive FIFO. After that, the receive FIFO must yield exactly the words of the first burst. A slave model in the bench follows the serial clock edges under all eight combinations of polarity, phase and bit order. It checks the slave-select lines on every clock.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_STORE = 2'd2
    } shift_state_t;

    localparam logic [7:0] ADDR_CTRL = 8'h60;
    localparam logic [7:0] ADDR_STAT = 8'h64;
    localparam logic [7:0] ADDR_TXD  = 8'h68;
    localparam logic [7:0] ADDR_RXD  = 8'h6C;
    localparam logic [7:0] ADDR_SSEL = 8'h70;

    localparam int CB_LOOP   = 0;
    localparam int CB_EN     = 1;
    localparam int CB_MASTER = 2;
    localparam int CB_CPOL   = 3;
    localparam int CB_CPHA   = 4;
    localparam int CB_TXCLR  = 5;
    localparam int CB_RXCLR  = 6;
    localparam int CB_MANUAL = 7;
    localparam int CB_HOLD   = 8;
    localparam int CB_LSB    = 9;

endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R7 / R8: a push into a full FIFO without a pop leaves the fill level unchanged
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (cnt == $past(cnt)));

    // R9: a clear leaves the FIFO empty on the next cycle
    p_clr_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
    import spi_host_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              permit,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              loopback,
    input  logic              miso,
    output logic              tx_pop,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word
);
    localparam int EDGES = 2 * WORD_W;
    localparam int IW    = $clog2(EDGES);
    localparam int DW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    shift_state_t       state, nxt;
    logic [DW-1:0]      div;
    logic [IW-1:0]      idx;
    logic [WORD_W-1:0]  tx_sh, rx_sh;
    logic               sclk_q;
    logic               tick, last_edge, leading, samp, shft, sin, start;

    assign tick      = (div == DW'(CLK_DIV - 1));
    assign last_edge = (idx == IW'(EDGES - 1));
    assign leading   = ~idx[0];
    assign samp      = leading ^ cpha;
    assign shft      = !samp && !(cpha && idx == '0) && !(!cpha && last_edge);
    assign start     = permit && tx_avail;
    assign sin       = loopback ? mosi : miso;

    // next-state logic: start, last edge, done
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) nxt = ST_STORE;
            ST_STORE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs decoded from state
    always_comb begin
        tx_pop  = (state == ST_IDLE) && start;
        busy    = (state != ST_IDLE);
        rx_push = (state == ST_STORE);
        sclk    = sclk_q;
        mosi    = lsb_first ? tx_sh[0] : tx_sh[WORD_W-1];
        rx_word = rx_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            div    <= '0;
            idx    <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sclk_q <= cpol;
                    div    <= '0;
                    idx    <= '0;
                    if (start) begin
                        tx_sh <= tx_word;
                        rx_sh <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        div    <= '0;
                        idx    <= idx + 1'b1;
                        sclk_q <= ~sclk_q;
                        if (samp)
                            rx_sh <= lsb_first ? {sin, rx_sh[WORD_W-1:1]}
                                               : {rx_sh[WORD_W-2:0], sin};
                        if (shft)
                            tx_sh <= lsb_first ? {1'b0, tx_sh[WORD_W-1:1]}
                                               : {tx_sh[WORD_W-2:0], 1'b0};
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                ST_STORE: begin
                    div <= '0;
                end
                default: begin
                    div <= '0;
                end
            endcase
        end
    end

    // R4: after an even number of edges the clock is back at its idle level
    p_sclk_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE) |-> (sclk_q == cpol));

    // R3: a word in flight always runs to the store state (edge index never jumps while shifting)
    p_edge_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !tick) |=> (idx == $past(idx)));

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 2,
    parameter int NUM_SS     = 4,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    logic c_loop, c_en, c_master, c_cpol, c_cpha, c_manual, c_hold, c_lsb;
    logic [NUM_SS-1:0] ss_reg;

    logic wr_ctrl, wr_txd, wr_ssel, rd_rxd;
    logic tx_clr, rx_clr;
    logic tx_pop, tx_empty, tx_full;
    logic rx_push, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_dout, rx_din, rx_dout;
    logic busy, permit;
    logic [DATA_W-1:0] ctrl_rd, stat_rd;

    assign wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));
    assign wr_txd  = wr_en && (addr == ADDR_W'(ADDR_TXD));
    assign wr_ssel = wr_en && (addr == ADDR_W'(ADDR_SSEL));
    assign rd_rxd  = rd_en && (addr == ADDR_W'(ADDR_RXD));
    assign tx_clr  = wr_ctrl && wdata[CB_TXCLR];
    assign rx_clr  = wr_ctrl && wdata[CB_RXCLR];
    assign permit  = c_en && c_master && !c_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_loop   <= 1'b0;
            c_en     <= 1'b0;
            c_master <= 1'b0;
            c_cpol   <= 1'b0;
            c_cpha   <= 1'b0;
            c_manual <= 1'b0;
            c_hold   <= 1'b1;
            c_lsb    <= 1'b0;
            ss_reg   <= '1;
        end else begin
            if (wr_ctrl) begin
                c_loop   <= wdata[CB_LOOP];
                c_en     <= wdata[CB_EN];
                c_master <= wdata[CB_MASTER];
                c_cpol   <= wdata[CB_CPOL];
                c_cpha   <= wdata[CB_CPHA];
                c_manual <= wdata[CB_MANUAL];
                c_hold   <= wdata[CB_HOLD];
                c_lsb    <= wdata[CB_LSB];
            end
            if (wr_ssel) ss_reg <= wdata[NUM_SS-1:0];
        end
    end

    spi_host_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(wr_txd), .din(wdata[WORD_W-1:0]),
        .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
    );

    spi_host_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .din(rx_din),
        .pop(rd_rxd), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
    );

    spi_host_shifter #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .permit(permit),
        .tx_avail(!tx_empty), .tx_word(tx_dout),
        .cpol(c_cpol), .cpha(c_cpha), .lsb_first(c_lsb), .loopback(c_loop),
        .miso(miso), .tx_pop(tx_pop), .sclk(sclk), .mosi(mosi),
        .busy(busy), .rx_push(rx_push), .rx_word(rx_din)
    );

    assign ss_n = (c_manual || busy) ? ss_reg : '1;

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CB_LOOP]   = c_loop;
        ctrl_rd[CB_EN]     = c_en;
        ctrl_rd[CB_MASTER] = c_master;
        ctrl_rd[CB_CPOL]   = c_cpol;
        ctrl_rd[CB_CPHA]   = c_cpha;
        ctrl_rd[CB_MANUAL] = c_manual;
        ctrl_rd[CB_HOLD]   = c_hold;
        ctrl_rd[CB_LSB]    = c_lsb;
        stat_rd = '0;
        stat_rd[0] = rx_empty;
        stat_rd[1] = rx_full;
        stat_rd[2] = tx_empty;
        stat_rd[3] = tx_full;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADDR_CTRL): rdata = ctrl_rd;
            ADDR_W'(ADDR_STAT): rdata = stat_rd;
            ADDR_W'(ADDR_RXD):  rdata[WORD_W-1:0] = rx_empty ? '0 : rx_dout;
            ADDR_W'(ADDR_SSEL): rdata[NUM_SS-1:0] = ss_reg;
            default:            rdata = '0;
        endcase
    end

    // R2 / R12: a word leaves the transmit FIFO only when enabled, master and not held
    p_pop_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (c_en && c_master && !c_hold));

    // R8: a full receive FIFO stays full until software pops or clears it
    p_rx_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_rxd && !rx_clr) |=> rx_full);

endmodule

// File: tb/test_spi_host_ctrl.sv
`timescale 1ns/1ps
module test_spi_host_ctrl;
    localparam int W = 8, DEPTH = 4, D = 2, NSS = 4;
    localparam int CTRL = 'h60, STAT = 'h64, TXD = 'h68, RXD = 'h6C, SSEL = 'h70;
    localparam int LOOP = 'h1, EN = 'h2, MS = 'h4, CPOL = 'h8, CPHA = 'h10;
    localparam int TXR = 'h20, RXR = 'h40, MAN = 'h80, INH = 'h100, LSB = 'h200;
    localparam int WORD_CYC = 2 * W * D + 3;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, miso;
    logic [7:0] addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic sclk, mosi;
    logic [NSS-1:0] ss_n;

    spi_host_ctrl #(.WORD_W(W), .FIFO_DEPTH(DEPTH), .CLK_DIV(D), .NUM_SS(NSS)) i_spi_host_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, edges = 0, n = 0;
    bit finished = 0, hold = 0;
    logic m_cpol = 0, m_cpha = 0, m_lsb = 0, m_manual = 0, sclk_q = 0;
    logic [NSS-1:0] exp_ss = '1;
    logic [W-1:0] cap = 0, slv_cur = 0;
    logic [W-1:0] cap_q[$], slv_q[$];

    assign miso = m_lsb ? slv_cur[n] : slv_cur[W-1-n];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural slave and per-clock select-line reference, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk !== sclk_q) begin
                edges++;
                if (!m_manual && !hold) chk(ss_n === exp_ss, "R11 select during word", ss_n, exp_ss);
                if ((sclk != m_cpol) ^ m_cpha) begin
                    cap = m_lsb ? {mosi, cap[W-1:1]} : {cap[W-2:0], mosi};
                    n++;
                    if (n == W) begin
                        cap_q.push_back(cap);
                        n = 0;
                        if (slv_q.size() > 0) slv_cur = slv_q.pop_front();
                    end
                end
            end
            sclk_q = sclk;
            if (m_manual && !hold) chk(ss_n === exp_ss, "R10 manual select", ss_n, exp_ss);
        end
    end

    task automatic bwr(input int a, input int d);
        hold = 1;
        @(negedge clk); addr = 8'(a); wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
        hold = 0;
    endtask

    task automatic brd(input int a, output logic [31:0] d);
        @(negedge clk); addr = 8'(a); rd_en = 1;
        #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic set_mode(input int v);
        hold = 1;
        bwr(CTRL, v);
        m_cpol = v[3]; m_cpha = v[4]; m_manual = v[7]; m_lsb = v[9];
        repeat (2) @(negedge clk);
        edges = 0; n = 0; cap_q.delete(); sclk_q = sclk;
        hold = 0;
    endtask

    task automatic set_ss(input logic [NSS-1:0] v);
        hold = 1;
        bwr(SSEL, v);
        exp_ss = v;
        hold = 0;
    endtask

    task automatic run_burst(input int mode, input logic [W-1:0] base, input int cnt, input string tag);
        logic [31:0] r;
        logic [W-1:0] tw[$];
        set_mode(mode | INH);
        slv_q.delete();
        for (int k = 0; k < cnt; k++) begin
            tw.push_back(base + W'(k * 37));
            bwr(TXD, tw[k]);
            slv_q.push_back(~tw[k]);
        end
        slv_cur = slv_q.pop_front();
        bwr(CTRL, mode);
        repeat (cnt * WORD_CYC + 10) @(negedge clk);
        chk(edges == cnt * 2 * W, {tag, " edge count"}, edges, cnt * 2 * W);
        for (int k = 0; k < cnt; k++)
            chk(k < cap_q.size() && cap_q[k] == tw[k], {tag, " serial out"},
                (k < cap_q.size()) ? cap_q[k] : 0, tw[k]);
        chk(sclk == mode[3], {tag, " clock idle level"}, sclk, mode[3]);
        for (int k = 0; k < cnt; k++) begin
            brd(RXD, r);
            chk(r[W-1:0] == (mode[0] ? tw[k] : ~tw[k]), {tag, " received word"},
                r, mode[0] ? tw[k] : ~tw[k]);
        end
    endtask

    initial begin
        logic [31:0] r;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        brd(CTRL, r); chk(r == 'h100, "R1 control", r, 'h100);
        brd(STAT, r); chk(r == 'h05, "R1 status", r, 'h05);
        chk(ss_n == '1, "R1 selects", ss_n, 'hF);
        chk(sclk == 0, "R1 clock", sclk, 0);

        // R2 hold keeps words queued
        set_ss(4'hE);
        set_mode(EN | MS | MAN | INH);
        bwr(TXD, 'hA5); bwr(TXD, 'h3C);
        repeat (80) @(negedge clk);
        chk(edges == 0, "R2 no edges while held", edges, 0);
        brd(STAT, r); chk(r == 'h01, "R2 tx not empty", r, 'h01);
        bwr(CTRL, EN | MS | MAN | TXR | INH);

        // R3 plain burst, R10 manual select checked each clock
        run_burst(EN | MS | MAN, 8'hA5, 3, "R3");
        brd(STAT, r); chk(r == 'h05, "R3 status after burst", r, 'h05);

        // R4 polarity/phase and R5 bit order, all eight mixes
        for (int m = 0; m < 8; m++)
            run_burst(EN | MS | MAN | (m[0] ? CPOL : 0) | (m[1] ? CPHA : 0) | (m[2] ? LSB : 0),
                      W'(8'h13 + m * 29), 2, m[2] ? "R5" : "R4");

        // R6 loopback ignores miso
        run_burst(EN | MS | MAN | LOOP | CPHA, 8'h96, 2, "R6");
        brd(CTRL, r); chk(r[0] == 1, "R6 loop readback", r[0], 1);

        // R7 depth by counting writes, extra write dropped
        set_mode(EN | MS | MAN | INH);
        cnt = 0;
        do begin
            bwr(TXD, 'h40 + cnt); cnt++;
            brd(STAT, r);
        end while (!r[3] && cnt < 16);
        chk(cnt == DEPTH, "R7 depth count", cnt, DEPTH);
        bwr(TXD, 'hEE);
        slv_q.delete();
        for (int k = 0; k < DEPTH; k++) slv_q.push_back(W'('hC0 + k));
        slv_cur = slv_q.pop_front();
        bwr(CTRL, EN | MS | MAN);
        repeat ((DEPTH + 2) * WORD_CYC) @(negedge clk);
        chk(edges == DEPTH * 2 * W, "R7 extra word dropped", edges, DEPTH * 2 * W);
        for (int k = 0; k < DEPTH; k++)
            chk(k < cap_q.size() && cap_q[k] == W'('h40 + k), "R7 order",
                (k < cap_q.size()) ? cap_q[k] : 0, 'h40 + k);
        brd(STAT, r); chk(r[1] == 1, "R8 rx full", r, 'h6);

        // R8 overflow keeps stored words
        set_mode(EN | MS | MAN | INH);
        slv_q.delete(); slv_q.push_back(8'h11); slv_q.push_back(8'h22);
        slv_cur = slv_q.pop_front();
        bwr(TXD, 'h77); bwr(TXD, 'h78);
        bwr(CTRL, EN | MS | MAN);
        repeat (3 * WORD_CYC) @(negedge clk);
        chk(edges == 4 * W, "R8 second burst shifted", edges, 4 * W);
        for (int k = 0; k < DEPTH; k++) begin
            brd(RXD, r); chk(r == 'hC0 + k, "R8 kept word", r, 'hC0 + k);
        end
        brd(STAT, r); chk(r == 'h05, "R8 rx empty after drain", r, 'h05);

        // R12 enable and master both required
        set_mode(MS | MAN | INH);
        bwr(TXD, 'h55);
        bwr(CTRL, MS | MAN);
        repeat (60) @(negedge clk);
        chk(edges == 0, "R12 disabled", edges, 0);
        set_mode(EN | MAN | INH);
        bwr(CTRL, EN | MAN);
        repeat (60) @(negedge clk);
        chk(edges == 0, "R12 not master", edges, 0);

        // R9 FIFO reset bits
        bwr(CTRL, EN | MS | MAN | INH | TXR);
        brd(STAT, r); chk(r == 'h05, "R9 tx emptied", r, 'h05);
        brd(CTRL, r); chk(r[6:5] == 0, "R9 reset bits read 0", r[6:5], 0);
        set_mode(EN | MS | MAN | INH);
        bwr(CTRL, EN | MS | MAN);
        repeat (60) @(negedge clk);
        chk(edges == 0, "R9 nothing left to send", edges, 0);
        set_mode(EN | MS | MAN | LOOP | INH);
        bwr(TXD, 'h5E);
        bwr(CTRL, EN | MS | MAN | LOOP);
        repeat (WORD_CYC + 10) @(negedge clk);
        brd(STAT, r); chk(r[0] == 0, "R9 rx holds word", r, 'h04);
        bwr(CTRL, EN | MS | MAN | INH | RXR);
        brd(STAT, r); chk(r == 'h05, "R9 rx emptied", r, 'h05);

        // R11 automatic select
        set_ss(4'hB);
        set_mode(EN | MS | INH);
        chk(ss_n == '1, "R11 idle high", ss_n, 'hF);
        run_burst(EN | MS, 8'h2D, 2, "R11");
        chk(ss_n == '1, "R11 high after burst", ss_n, 'hF);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule